// File: doc/BRIEF.md
# Debug breakpoint controller

This block sits next to a small packet-processing core and watches its program counter, data address, read data, write data and hardware context. Eight comparators (two on the program counter, two on the data address, two on read data, two on write data) each have a value, a bit-ignore mask and a configuration byte. Two trigger groups AND together any subset of comparator matches, and a breakpoint is met when either group fires.

On a met breakpoint (when enabled), a stop command or an incoming break-in (when enabled), the controller raises `halt_o` and captures the cause. The halt cause flags and the breakpoint reason stay frozen until a restart. A single step lets the core retire one instruction and halts it again. A one-cycle break-out pulse can be raised by command, on halt entry, or on break-in. Software reaches all of this through a word-wide register port with a write strobe and a combinational read.

Register map (5-bit address): 0x00 command, 0x01 options, 0x02 trigger, 0x03 status, 0x04 reason, 0x08+k comparator value, 0x10+k comparator mask, 0x18+k comparator configuration. Comparator index k: 0-1 program counter, 2-3 data address, 4-5 read data, 6-7 write data.

Top module: `dbg_brk_ctrl`

## Requirements
- R1: After reset `halt_o` and `break_out_o` are low, and the status flags (bits 2:0), reason, trigger, option and every comparator configuration register read 0.
- R2: An enabled comparator (configuration bit 7) matches when its bus is qualified and ((bus XOR value) AND NOT mask) is zero; a mask bit of 1 ignores that bit. Program-counter comparators are always qualified, data-address comparators on `rd_valid_i` or `wr_valid_i`, read-data comparators on `rd_valid_i`, write-data comparators on `wr_valid_i`. A disabled comparator never matches.
- R3: With configuration bit 4 set, a comparator matches only when bit `ctx_i` of configuration bits 3:0 is 1.
- R4: On read-data and write-data comparators, configuration bit 5 requires bus >= value and bit 6 requires bus <= value (unsigned), replacing the masked equality; on program-counter and data-address comparators these bits are ignored and masked equality applies.
- R5: A trigger write carries a 2-bit code for group g, comparator k at bits g*16+2k+1:g*16+2k; code 3 enables, code 2 disables, codes 0 and 1 leave the enable unchanged. The trigger register reads back the enables at bit g*8+k.
- R6: The option register uses the same codes at bits 1:0 (break-out on halt entry), 3:2 (break-out on break-in), 5:4 (halt on break-in) and 7:6 (halt on breakpoint), and reads them back at bits 0, 1, 2 and 3.
- R7: A group fires when every comparator enabled in it matches in the same cycle; a group with no enables never fires; a breakpoint is met when either group fires.
- R8: With halt on breakpoint on, a met breakpoint raises `halt_o` on the next clock edge, sets status bit 2 and latches the reason: bits 7:0 every matching comparator, bits 8+2j and 9+2j the lower-or-equal and greater-or-equal results of enabled value comparator j (k=4+j), bits 17:16 the context.
- R9: While halted, status flags and reason do not change until a restart, whatever the buses, context or break-in do.
- R10: Command bit 0 restarts (clears halt, flags and reason); bit 1 halts and sets status bit 0; when both are written together the core ends halted with status bit 0 set.
- R11: Command bit 2 while halted drops `halt_o` until a cycle with `retire_i` high, and `halt_o` is high again after that clock edge.
- R12: With halt on break-in on, a `break_in_i` cycle halts the core and sets status bit 1; with it off, break-in does not halt.
- R13: `break_out_o` pulses for one cycle after a command write with bit 3, together with halt entry when break-out on halt is on, and after a `break_in_i` cycle when break-out on break-in is on.
- R14: Status bits 31:16 show the current `pc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_i | input | PC_W | Core program counter |
| daddr_i | input | DADDR_W | Core data address |
| rdata_i | input | DATA_W | Core read data |
| rd_valid_i | input | 1 | Read access this cycle |
| wdata_i | input | DATA_W | Core write data |
| wr_valid_i | input | 1 | Write access this cycle |
| ctx_i | input | 2 | Active hardware context |
| retire_i | input | 1 | Core retires an instruction this cycle |
| break_in_i | input | 1 | External break request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| halt_o | output | 1 | Core halt request |
| break_out_o | output | 1 | One-cycle break-out pulse |

## Verification
The comparator table drives each of the eight comparators alone through a single trigger enable, with exact, near-miss and masked-off bus values, disabled configurations, greater-or-equal, lower-or-equal and both-bound cases, a magnitude mode set on an address comparator, and allowed versus blocked contexts; each row distinguishes whether the halt comes from a true match or a wrong compare mode. Directed cases separate an AND of two comparators from a single one, an empty group from an armed one, and the second group from the first. Freezing is told apart from live capture by moving buses, context and break-in while halted, and step, stop-plus-restart and break-out sources are each exercised on their own.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
  localparam int REG_W   = 32;
  localparam int RA_W    = 5;
  localparam int NUM_CMP = 8;
  localparam int NUM_GRP = 2;
  localparam int NUM_VAL = 4;
  localparam int CTX_N   = 4;
  localparam int CTX_W   = $clog2(CTX_N);
  localparam int RSN_W   = CTX_W + 2 * NUM_VAL + NUM_CMP;

  // configuration byte fields
  localparam int CFG_CTX_EN = 4;
  localparam int CFG_GE     = 5;
  localparam int CFG_LE     = 6;
  localparam int CFG_EN     = 7;

  // register bank in addr[4:3], index in addr[2:0]
  typedef enum logic [1:0] {
    BANK_CTRL = 2'd0,
    BANK_VAL  = 2'd1,
    BANK_MSK  = 2'd2,
    BANK_CFG  = 2'd3
  } bank_e;

  localparam logic [2:0] IDX_CMD  = 3'd0;
  localparam logic [2:0] IDX_OPT  = 3'd1;
  localparam logic [2:0] IDX_TRIG = 3'd2;
  localparam logic [2:0] IDX_STAT = 3'd3;
  localparam logic [2:0] IDX_RSN  = 3'd4;

  typedef struct packed {
    logic stop_bp;
    logic stop_brkin;
    logic bout_brkin;
    logic bout_halt;
  } opt_t;

  function automatic logic code_apply(logic cur, logic [1:0] code);
    return code[1] ? code[0] : cur;
  endfunction
endpackage

// File: rtl/dbg_brk_cmp.sv
module dbg_brk_cmp
  import dbg_brk_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit HAS_MAG = 1'b0
) (
  input  logic [DATA_W-1:0] bus_i,
  input  logic              vld_i,
  input  logic [CTX_W-1:0]  ctx_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [7:0]        cfg_i,
  output logic              match_o,
  output logic              le_o,
  output logic              ge_o
);
  logic en, ctx_ok, eq, hit;

  assign en     = cfg_i[CFG_EN];
  assign ctx_ok = !cfg_i[CFG_CTX_EN] || cfg_i[ctx_i];
  assign eq     = ((bus_i ^ value_i) & ~mask_i) == '0;

  if (HAS_MAG) begin : g_mag
    logic le, ge, mag_sel;
    assign le      = bus_i <= value_i;
    assign ge      = bus_i >= value_i;
    assign mag_sel = cfg_i[CFG_GE] | cfg_i[CFG_LE];
    assign hit     = mag_sel ? ((!cfg_i[CFG_GE] || ge) && (!cfg_i[CFG_LE] || le)) : eq;
    assign le_o    = en & le;
    assign ge_o    = en & ge;
  end else begin : g_eq
    assign hit  = eq;
    assign le_o = 1'b0;
    assign ge_o = 1'b0;
  end

  assign match_o = en && vld_i && ctx_ok && hit;
endmodule

// File: rtl/dbg_brk_trig.sv
module dbg_brk_trig
  import dbg_brk_pkg::*;
(
  input  logic [NUM_CMP-1:0]         match_i,
  input  logic [NUM_GRP*NUM_CMP-1:0] en_i,
  output logic [NUM_GRP-1:0]         fire_o,
  output logic                       bp_met_o
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [NUM_CMP-1:0] en;
    assign en        = en_i[g*NUM_CMP +: NUM_CMP];
    assign fire_o[g] = (en != '0) && ((match_i & en) == en);
  end

  assign bp_met_o = |fire_o;
endmodule

// File: rtl/dbg_brk_halt.sv
module dbg_brk_halt
  import dbg_brk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_restart_i,
  input  logic             cmd_stop_i,
  input  logic             cmd_step_i,
  input  logic             cmd_bout_i,
  input  opt_t             opt_i,
  input  logic             bp_met_i,
  input  logic [RSN_W-1:0] cause_i,
  input  logic             break_in_i,
  input  logic             retire_i,
  output logic             halt_o,
  output logic             break_out_o,
  output logic [2:0]       flags_o,
  output logic [RSN_W-1:0] reason_o
);
  logic             halt_q, step_q, bout_q;
  logic [2:0]       flags_q;
  logic [RSN_W-1:0] reason_q;

  logic             halt_d, step_d, enter, bout_d;
  logic [2:0]       flags_d;
  logic [RSN_W-1:0] reason_d;

  always_comb begin
    halt_d   = halt_q;
    step_d   = step_q;
    flags_d  = flags_q;
    reason_d = reason_q;
    enter    = 1'b0;
    if (cmd_restart_i) begin
      halt_d   = 1'b0;
      step_d   = 1'b0;
      flags_d  = '0;
      reason_d = '0;
    end
    if (!halt_d && !step_d) begin
      if (cmd_stop_i) begin
        flags_d[0] = 1'b1;
        enter      = 1'b1;
      end
      if (break_in_i && opt_i.stop_brkin) begin
        flags_d[1] = 1'b1;
        enter      = 1'b1;
      end
      if (bp_met_i && opt_i.stop_bp) begin
        flags_d[2] = 1'b1;
        reason_d   = cause_i;
        enter      = 1'b1;
      end
      if (enter) halt_d = 1'b1;
    end else if (halt_d && cmd_step_i) begin
      halt_d = 1'b0;
      step_d = 1'b1;
    end else if (step_d && retire_i) begin
      step_d = 1'b0;
      halt_d = 1'b1;
    end
    bout_d = cmd_bout_i | (enter & opt_i.bout_halt) | (break_in_i & opt_i.bout_brkin);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q   <= 1'b0;
      step_q   <= 1'b0;
      bout_q   <= 1'b0;
      flags_q  <= '0;
      reason_q <= '0;
    end else begin
      halt_q   <= halt_d;
      step_q   <= step_d;
      bout_q   <= bout_d;
      flags_q  <= flags_d;
      reason_q <= reason_d;
    end
  end

  assign halt_o      = halt_q;
  assign break_out_o = bout_q;
  assign flags_o     = flags_q;
  assign reason_o    = reason_q;

  assert_halt_on_bp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_q && !step_q && bp_met_i && opt_i.stop_bp) |=> halt_q);

  assert_reason_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !cmd_restart_i) |=> ($stable(reason_q) && $stable(flags_q)));

  assert_restart_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_restart_i && !cmd_stop_i) |=> !flags_q[0]);

  assert_step_rehalt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q && retire_i && !cmd_restart_i) |=> halt_q);

  assert_step_not_halted_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(halt_q && step_q));
endmodule

// File: rtl/dbg_brk_ctrl.sv
module dbg_brk_ctrl
  import dbg_brk_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int DADDR_W = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [DADDR_W-1:0] daddr_i,
  input  logic [DATA_W-1:0]  rdata_i,
  input  logic               rd_valid_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               wr_valid_i,
  input  logic [CTX_W-1:0]   ctx_i,
  input  logic               retire_i,
  input  logic               break_in_i,
  input  logic               reg_we_i,
  input  logic [RA_W-1:0]    reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               halt_o,
  output logic               break_out_o
);
  localparam int TRIG_W = NUM_GRP * NUM_CMP;

  logic [DATA_W-1:0] val_q [NUM_CMP];
  logic [DATA_W-1:0] msk_q [NUM_CMP];
  logic [7:0]        cfg_q [NUM_CMP];
  logic [TRIG_W-1:0] trig_q;
  opt_t              opt_q;

  bank_e      bank;
  logic [2:0] idx;
  logic       wr_ctrl;

  assign bank    = bank_e'(reg_addr_i[4:3]);
  assign idx     = reg_addr_i[2:0];
  assign wr_ctrl = reg_we_i && (bank == BANK_CTRL);

  // comparator registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_CMP; k++) begin
        val_q[k] <= '0;
        msk_q[k] <= '0;
        cfg_q[k] <= '0;
      end
    end else if (reg_we_i) begin
      case (bank)
        BANK_VAL: val_q[idx] <= reg_wdata_i[DATA_W-1:0];
        BANK_MSK: msk_q[idx] <= reg_wdata_i[DATA_W-1:0];
        BANK_CFG: cfg_q[idx] <= reg_wdata_i[7:0];
        default:  ;
      endcase
    end
  end

  // coded-field registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= '0;
      opt_q  <= '0;
    end else if (wr_ctrl) begin
      if (idx == IDX_TRIG) begin
        for (int g = 0; g < NUM_GRP; g++) begin
          for (int k = 0; k < NUM_CMP; k++) begin
            trig_q[g*NUM_CMP+k] <= code_apply(trig_q[g*NUM_CMP+k], reg_wdata_i[g*16+2*k +: 2]);
          end
        end
      end
      if (idx == IDX_OPT) begin
        opt_q.bout_halt  <= code_apply(opt_q.bout_halt,  reg_wdata_i[1:0]);
        opt_q.bout_brkin <= code_apply(opt_q.bout_brkin, reg_wdata_i[3:2]);
        opt_q.stop_brkin <= code_apply(opt_q.stop_brkin, reg_wdata_i[5:4]);
        opt_q.stop_bp    <= code_apply(opt_q.stop_bp,    reg_wdata_i[7:6]);
      end
    end
  end

  logic cmd_wr;
  assign cmd_wr = wr_ctrl && (idx == IDX_CMD);

  // comparators
  logic [NUM_CMP-1:0] match, le_w, ge_w;

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    logic [DATA_W-1:0] bus;
    logic              vld;
    if (k < 2) begin : g_pc
      assign bus = DATA_W'(pc_i);
      assign vld = 1'b1;
    end else if (k < 4) begin : g_addr
      assign bus = DATA_W'(daddr_i);
      assign vld = rd_valid_i | wr_valid_i;
    end else if (k < 6) begin : g_rd
      assign bus = rdata_i;
      assign vld = rd_valid_i;
    end else begin : g_wr
      assign bus = wdata_i;
      assign vld = wr_valid_i;
    end

    dbg_brk_cmp #(
      .DATA_W (DATA_W),
      .HAS_MAG(k >= 4 ? 1'b1 : 1'b0)
    ) u_cmp (
      .bus_i  (bus),
      .vld_i  (vld),
      .ctx_i  (ctx_i),
      .value_i(val_q[k]),
      .mask_i (msk_q[k]),
      .cfg_i  (cfg_q[k]),
      .match_o(match[k]),
      .le_o   (le_w[k]),
      .ge_o   (ge_w[k])
    );
  end

  logic [2*NUM_VAL-1:0] lege;
  for (genvar j = 0; j < NUM_VAL; j++) begin : g_lege
    assign lege[2*j]   = le_w[NUM_CMP-NUM_VAL+j];
    assign lege[2*j+1] = ge_w[NUM_CMP-NUM_VAL+j];
  end

  logic [NUM_GRP-1:0] fire;
  logic               bp_met;

  dbg_brk_trig u_trig (
    .match_i (match),
    .en_i    (trig_q),
    .fire_o  (fire),
    .bp_met_o(bp_met)
  );

  logic [2:0]       flags;
  logic [RSN_W-1:0] reason;

  dbg_brk_halt u_halt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_restart_i(cmd_wr & reg_wdata_i[0]),
    .cmd_stop_i   (cmd_wr & reg_wdata_i[1]),
    .cmd_step_i   (cmd_wr & reg_wdata_i[2]),
    .cmd_bout_i   (cmd_wr & reg_wdata_i[3]),
    .opt_i        (opt_q),
    .bp_met_i     (bp_met),
    .cause_i      ({ctx_i, lege, match}),
    .break_in_i   (break_in_i),
    .retire_i     (retire_i),
    .halt_o       (halt_o),
    .break_out_o  (break_out_o),
    .flags_o      (flags),
    .reason_o     (reason)
  );

  // read port
  always_comb begin
    reg_rdata_o = '0;
    case (bank)
      BANK_CTRL: begin
        case (idx)
          IDX_OPT:  reg_rdata_o = REG_W'(opt_q);
          IDX_TRIG: reg_rdata_o = REG_W'(trig_q);
          IDX_STAT: reg_rdata_o = {16'(pc_i), 13'd0, flags};
          IDX_RSN:  reg_rdata_o = REG_W'(reason);
          default:  reg_rdata_o = '0;
        endcase
      end
      BANK_VAL: reg_rdata_o = REG_W'(val_q[idx]);
      BANK_MSK: reg_rdata_o = REG_W'(msk_q[idx]);
      BANK_CFG: reg_rdata_o = REG_W'(cfg_q[idx]);
      default:  reg_rdata_o = '0;
    endcase
  end

  assert_disabled_no_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[0][CFG_EN] == 1'b0) |-> !match[0]);

  assert_empty_grp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q == '0) |-> !bp_met);

  assert_bout_pulse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (break_out_o && !$past(cmd_wr) && !$past(break_in_i)) |-> $rose(halt_o));
endmodule

// File: tb/test_dbg_brk_ctrl.sv
module test_dbg_brk_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pc = '0;
  logic [15:0] daddr = '0;
  logic [31:0] rdata = '0;
  logic        rd_valid = 1'b0;
  logic [31:0] wdata = '0;
  logic        wr_valid = 1'b0;
  logic [1:0]  ctx = '0;
  logic        retire = 1'b0;
  logic        break_in = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        halt, bout;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dbg_brk_ctrl i_dbg_brk_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .daddr_i(daddr), .rdata_i(rdata),
    .rd_valid_i(rd_valid), .wdata_i(wdata), .wr_valid_i(wr_valid), .ctx_i(ctx),
    .retire_i(retire), .break_in_i(break_in), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .halt_o(halt), .break_out_o(bout)
  );

  localparam logic [4:0] A_CMD = 5'h00, A_OPT = 5'h01, A_TRIG = 5'h02,
                         A_STAT = 5'h03, A_RSN = 5'h04,
                         A_VAL = 5'h08, A_MSK = 5'h10, A_CFG = 5'h18;
  localparam logic [31:0] TRIG_ALL_OFF = 32'hAAAA_AAAA;

  typedef struct packed {
    logic [2:0]  k;
    logic [31:0] val;
    logic [31:0] msk;
    logic [7:0]  cfg;
    logic [31:0] bus;
    logic [1:0]  ctx;
    logic        exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'h1234, 32'h0, 8'h80, 32'h1234, 2'd0, 1'b1},  // R2 exact pc
    '{3'd1, 32'h1234, 32'h0, 8'h80, 32'h1235, 2'd0, 1'b0},  // R2 near miss
    '{3'd1, 32'h1230, 32'hF, 8'h80, 32'h123A, 2'd0, 1'b1},  // R2 masked bits
    '{3'd2, 32'h00AB, 32'h0, 8'h00, 32'h00AB, 2'd0, 1'b0},  // R2 disabled
    '{3'd3, 32'h00AB, 32'h0, 8'h80, 32'h00AB, 2'd0, 1'b1},  // R2 address
    '{3'd4, 32'd100,  32'h0, 8'hA0, 32'd150,  2'd0, 1'b1},  // R4 ge hit
    '{3'd4, 32'd100,  32'h0, 8'hA0, 32'd50,   2'd0, 1'b0},  // R4 ge miss
    '{3'd5, 32'd100,  32'h0, 8'hC0, 32'd100,  2'd0, 1'b1},  // R4 le boundary
    '{3'd6, 32'd100,  32'h0, 8'hC0, 32'd101,  2'd0, 1'b0},  // R4 le miss
    '{3'd7, 32'd7,    32'h0, 8'hE0, 32'd7,    2'd0, 1'b1},  // R4 both bounds
    '{3'd2, 32'd100,  32'h0, 8'hA0, 32'd150,  2'd0, 1'b0},  // R4 ge ignored on addr
    '{3'd0, 32'd5,    32'h0, 8'h94, 32'd5,    2'd2, 1'b1},  // R3 ctx allowed
    '{3'd0, 32'd5,    32'h0, 8'h94, 32'd5,    2'd1, 1'b0}   // R3 ctx blocked
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_break_in();
    @(negedge clk); break_in = 1'b1;
    @(negedge clk); break_in = 1'b0;
  endtask

  task automatic idle_bus();
    rd_valid = 1'b0; wr_valid = 1'b0; ctx = '0;
  endtask

  task automatic release_core();
    wr(A_TRIG, TRIG_ALL_OFF);
    wr(A_CMD, 32'h1);
  endtask

  bit done = 1'b0;

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2, s2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 halt", {31'd0, halt}, 32'd0);
    chk("R1 break_out", {31'd0, bout}, 32'd0);
    rd(A_STAT, r); chk("R1 status", r, 32'd0);
    rd(A_RSN, r);  chk("R1 reason", r, 32'd0);
    rd(A_TRIG, r); chk("R1 trigger", r, 32'd0);
    rd(A_OPT, r);  chk("R1 option", r, 32'd0);
    rd(A_CFG + 5'd3, r); chk("R1 cfg", r, 32'd0);

    // R5 trigger codes
    wr(A_TRIG, 32'h0000_000F); rd(A_TRIG, r); chk("R5 set two", r, 32'h0003);
    wr(A_TRIG, 32'h0003_0004); rd(A_TRIG, r); chk("R5 keep codes", r, 32'h0103);
    wr(A_TRIG, 32'h0000_0008); rd(A_TRIG, r); chk("R5 clear one", r, 32'h0101);
    wr(A_TRIG, TRIG_ALL_OFF);  rd(A_TRIG, r); chk("R5 all off", r, 32'h0);

    // R6 option codes
    wr(A_OPT, 32'h0000_00C3); rd(A_OPT, r); chk("R6 set", r, 32'h9);
    wr(A_OPT, 32'h0000_0080); rd(A_OPT, r); chk("R6 clear stop_bp", r, 32'h1);
    wr(A_OPT, 32'h0000_00C2); rd(A_OPT, r); chk("R6 swap", r, 32'h8);

    // comparator table (R2 R3 R4)
    for (int i = 0; i < NV; i++) begin
      idle_bus();
      wr(A_VAL + 5'(VECS[i].k), VECS[i].val);
      wr(A_MSK + 5'(VECS[i].k), VECS[i].msk);
      wr(A_CFG + 5'(VECS[i].k), 32'(VECS[i].cfg));
      pc = VECS[i].bus[15:0]; daddr = VECS[i].bus[15:0];
      rdata = VECS[i].bus; wdata = VECS[i].bus;
      rd_valid = 1'b1; wr_valid = 1'b1; ctx = VECS[i].ctx;
      wr(A_TRIG, 32'h3 << (2 * VECS[i].k));
      @(negedge clk);
      chk($sformatf("R2/R3/R4 vec%0d halt", i), {31'd0, halt}, {31'd0, VECS[i].exp});
      rd(A_RSN, r);
      chk($sformatf("R2/R3/R4 vec%0d reason", i), {31'd0, r[VECS[i].k]}, {31'd0, VECS[i].exp});
      wr(A_TRIG, TRIG_ALL_OFF);
      wr(A_CFG + 5'(VECS[i].k), 32'h0);
      wr(A_CMD, 32'h1);
      chk($sformatf("R10 vec%0d restart", i), {31'd0, halt}, 32'd0);
    end
    idle_bus();

    // R7 AND within group, empty group, second group
    wr(A_VAL + 5'd0, 32'h10); wr(A_CFG + 5'd0, 32'h80);
    wr(A_VAL + 5'd2, 32'h20); wr(A_CFG + 5'd2, 32'h80);
    pc = 16'h10; daddr = 16'h21; rd_valid = 1'b1;
    wr(A_TRIG, 32'h33);
    @(negedge clk);
    chk("R7 partial match", {31'd0, halt}, 32'd0);
    daddr = 16'h20;
    @(negedge clk); @(negedge clk);
    chk("R7 full match", {31'd0, halt}, 32'd1);
    release_core();
    wr(A_TRIG, TRIG_ALL_OFF);
    @(negedge clk); @(negedge clk);
    chk("R7 empty groups", {31'd0, halt}, 32'd0);
    wr(A_TRIG, 32'h3 << 20);
    @(negedge clk);
    chk("R7 second group", {31'd0, halt}, 32'd1);
    release_core();
    wr(A_CFG + 5'd0, 32'h0); wr(A_CFG + 5'd2, 32'h0);
    idle_bus();

    // R8 reason capture
    wr(A_VAL + 5'd0, 32'h40); wr(A_CFG + 5'd0, 32'h80);
    wr(A_VAL + 5'd4, 32'd100); wr(A_CFG + 5'd4, 32'hA0);
    pc = 16'h40; rdata = 32'd150; rd_valid = 1'b1; ctx = 2'd3;
    wr(A_TRIG, 32'h3 << 8);
    @(negedge clk);
    chk("R8 halt", {31'd0, halt}, 32'd1);
    rd(A_RSN, r);  chk("R8 reason", r, 32'h0003_0211);
    rd(A_STAT, r); chk("R8 status", r, 32'h0040_0004);

    // R9 frozen while halted
    ctx = 2'd0; rdata = 32'd50;
    wr(A_OPT, 32'h30);
    pulse_break_in();
    @(negedge clk);
    rd(A_RSN, r);  chk("R9 reason frozen", r, 32'h0003_0211);
    rd(A_STAT, r); chk("R9 status frozen", r, 32'h0040_0004);
    wr(A_TRIG, TRIG_ALL_OFF);
    wr(A_CFG + 5'd0, 32'h0); wr(A_CFG + 5'd4, 32'h0);
    wr(A_OPT, 32'h20);
    wr(A_CMD, 32'h1);
    idle_bus();
    rd(A_STAT, r); chk("R10 flags cleared", r, 32'h0040_0000);
    rd(A_RSN, r);  chk("R10 reason cleared", r, 32'h0);

    // R10 stop, stop+restart
    wr(A_CMD, 32'h2);
    chk("R10 stop halts", {31'd0, halt}, 32'd1);
    rd(A_STAT, r); chk("R10 stop flag", {29'd0, r[2:0]}, 32'd1);
    wr(A_CMD, 32'h3);
    chk("R10 both halted", {31'd0, halt}, 32'd1);
    rd(A_STAT, r); chk("R10 both flag", {29'd0, r[2:0]}, 32'd1);
    wr(A_CMD, 32'h1);
    chk("R10 restart", {31'd0, halt}, 32'd0);

    // R11 single step
    wr(A_CMD, 32'h2);
    wr(A_CMD, 32'h4);
    chk("R11 released", {31'd0, halt}, 32'd0);
    @(negedge clk); @(negedge clk);
    chk("R11 waits retire", {31'd0, halt}, 32'd0);
    retire = 1'b1;
    @(negedge clk);
    retire = 1'b0;
    chk("R11 rehalt", {31'd0, halt}, 32'd1);
    rd(A_STAT, r); chk("R11 flags kept", {29'd0, r[2:0]}, 32'd1);
    wr(A_CMD, 32'h1);

    // R12 break-in
    wr(A_OPT, 32'h30);
    pulse_break_in();
    chk("R12 halt", {31'd0, halt}, 32'd1);
    rd(A_STAT, r); chk("R12 flag", {29'd0, r[2:0]}, 32'd2);
    wr(A_CMD, 32'h1);
    wr(A_OPT, 32'h20);
    pulse_break_in();
    @(negedge clk);
    chk("R12 ignored", {31'd0, halt}, 32'd0);

    // R13 break-out
    wr(A_CMD, 32'h8);
    chk("R13 cmd pulse", {31'd0, bout}, 32'd1);
    @(negedge clk);
    chk("R13 one cycle", {31'd0, bout}, 32'd0);
    wr(A_OPT, 32'h03);
    wr(A_CMD, 32'h2);
    chk("R13 on halt entry", {30'd0, bout, halt}, 32'd3);
    wr(A_CMD, 32'h1);
    chk("R13 restart no pulse", {31'd0, bout}, 32'd0);
    wr(A_OPT, 32'h0E);
    pulse_break_in();
    chk("R13 on break-in", {30'd0, bout, halt}, 32'd2);
    @(negedge clk);
    chk("R13 break-in one cycle", {31'd0, bout}, 32'd0);

    // R14 live pc
    pc = 16'hBEEF;
    rd(A_STAT, r2);
    pc = 16'h0102;
    rd(A_STAT, s2);
    chk("R14 pc", {16'd0, r2[31:16]}, 32'hBEEF);
    chk("R14 pc follows", {16'd0, s2[31:16]}, 32'h0102);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule